// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block sits on the receive byte stream of a network port and watches the six bytes that open each frame. Those bytes form the destination address. While they arrive, the block runs three tests at once: an exact compare against the station's own address, a CRC-32 over the address that indexes a 64-bit multicast hash filter, and a check for the all-ones broadcast address. One cycle after the sixth byte it gives an accept flag and a code for the rule that matched. Both are held until the next frame starts.

The receive path pulses `sof` together with the first byte of a frame and `byte_vld` for every byte. Software-owned configuration feeds the block: the six station address bytes, the filter array and three enable bits. The block does not gather the rest of the frame and does not check its frame CRC. Its decision tells downstream logic whether to keep or drop the frame.

Top module: `af_filter_top`

## Requirements
- R1: After reset, `decision_vld` and `accept` are 0 and `match_class` is 0 (none).
- R2: `decision_vld` rises in the cycle after the clock edge that captures the sixth address byte, and not before. Idle cycles between address bytes are allowed.
- R3: When bit 0 of the first byte is 0 (unicast), the frame is accepted with class 1 only if every byte i (i = 0..5, in wire order) equals `own_addr[8i+7:8i]`. A mismatch in any single byte gives accept 0 and class 0.
- R4: An address of six 0xFF bytes is broadcast. With `bcast_en` = 1 it is accepted with class 3. With `bcast_en` = 0 it gives class 0 and is not tried against the hash filter.
- R5: A non-broadcast address with bit 0 of the first byte set is multicast. The hash index is bits 31:26 of a CRC-32 register after the six bytes. That register starts at all ones, uses the reflected polynomial 0xEDB88320, takes each byte least significant bit first, and gets no final inversion. The frame is accepted with class 2 only if `mcast_en` = 1 and `hash_filter[index]` = 1. Otherwise class is 0.
- R6: With `promisc` = 1 in the sixth-byte cycle, `accept` is 1 whatever the address. `match_class` still reports the rule that matched, or 0.
- R7: Once valid, the decision and its class hold unchanged, and further bytes are ignored, until `sof` is seen. The cycle after `sof`, `decision_vld` is 0.
- R8: A `sof` that arrives part-way through the address restarts collection, with that byte as the new first byte. Bytes that arrive after reset and before any `sof` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (asynchronous assert) |
| sof | input | 1 | Start of frame; qualifies the byte on `byte_in` as first byte |
| byte_vld | input | 1 | `byte_in` holds a valid frame byte |
| byte_in | input | 8 | Received byte |
| own_addr | input | 48 | Station address; byte i at bits 8i+7:8i |
| hash_filter | input | 64 | Multicast filter bits |
| bcast_en | input | 1 | Allow broadcast frames |
| mcast_en | input | 1 | Allow hash-matched multicast frames |
| promisc | input | 1 | Accept every frame |
| decision_vld | output | 1 | Decision outputs are valid |
| accept | output | 1 | Frame accepted |
| match_class | output | 2 | 0 none, 1 unicast, 2 multicast, 3 broadcast |

## Verification
A wrong byte counter shows at once as a decision that arrives a cycle early or late, or never, and the bench checks `decision_vld` on both sides of the sixth byte. A CRC register that picks up a wrong bit shows only on multicast frames, as a hash hit or miss on the wrong filter bit. So the bench sets the filter bit the model predicts and then clears it. Bad match or all-ones flags show as a wrong class right after the sixth byte, and tests that flip exactly one address byte at each position expose them. A decision register that does not hold shows as a change on the outputs during the extra bytes that follow the address.

// File: rtl/af_pkg.sv
package af_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_UCAST = 2'd1,
        CLS_MCAST = 2'd2,
        CLS_BCAST = 2'd3
    } af_class_e;

    localparam int          BYTE_W    = 8;
    localparam int          CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

endpackage

// File: rtl/af_crc_byte.sv
module af_crc_byte
    import af_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            if (acc[0] ^ data[b]) begin
                acc = (acc >> 1) ^ CRC_POLY;
            end else begin
                acc = acc >> 1;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/af_ucast_cmp.sv
module af_ucast_cmp
    import af_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_BYTES*BYTE_W-1:0] own_addr,
    input  logic [IDX_W-1:0]             idx,
    input  logic [BYTE_W-1:0]            data,
    output logic                         equal
);
    logic [ADDR_BYTES-1:0] hit;

    generate
        for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
            assign hit[g] = (idx == IDX_W'(g)) &&
                            (own_addr[g*BYTE_W +: BYTE_W] == data);
        end
    endgenerate

    assign equal = |hit;
endmodule

// File: rtl/af_decide.sv
module af_decide
    import af_pkg::*;
#(
    parameter int HASH_BITS = 6,
    localparam int FILT_W   = 1 << HASH_BITS
) (
    input  logic [CRC_W-1:0]  crc,
    input  logic              uc_equal,
    input  logic              all_ones,
    input  logic              group_bit,
    input  logic [FILT_W-1:0] hash_filter,
    input  logic              bcast_en,
    input  logic              mcast_en,
    input  logic              promisc,
    output af_class_e         cls,
    output logic              accept
);
    logic [HASH_BITS-1:0] hidx;
    assign hidx = crc[CRC_W-1 -: HASH_BITS];

    always_comb begin
        cls = CLS_NONE;
        if (all_ones) begin
            if (bcast_en) cls = CLS_BCAST;
        end else if (group_bit) begin
            if (mcast_en && hash_filter[hidx]) cls = CLS_MCAST;
        end else if (uc_equal) begin
            cls = CLS_UCAST;
        end
        accept = promisc || (cls != CLS_NONE);
    end
endmodule

// File: rtl/af_filter_top.sv
module af_filter_top
    import af_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
    localparam int FILT_W    = 1 << HASH_BITS,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [FILT_W-1:0] hash_filter,
    input  logic              bcast_en,
    input  logic              mcast_en,
    input  logic              promisc,
    output logic              decision_vld,
    output logic              accept,
    output logic [1:0]        match_class
);
    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             uc_ok;
        logic             ones;
        logic             group;
        logic             dvld;
        logic             acc;
        af_class_e        cls;
    } af_state_t;

    localparam af_state_t FRESH = '{
        armed: 1'b1, cnt: '0, crc: CRC_SEED, uc_ok: 1'b1, ones: 1'b1,
        group: 1'b0, dvld: 1'b0, acc: 1'b0, cls: CLS_NONE
    };
    localparam af_state_t IDLE = '{
        armed: 1'b0, cnt: '0, crc: CRC_SEED, uc_ok: 1'b0, ones: 1'b0,
        group: 1'b0, dvld: 1'b0, acc: 1'b0, cls: CLS_NONE
    };
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_BYTES);

    af_state_t st_q, st_d, base;
    logic [CRC_W-1:0] crc_nxt;
    logic             byte_eq;
    logic             take;
    logic             grp_nxt, uc_nxt, ones_nxt;
    af_class_e        cls_dec;
    logic             acc_dec;

    assign base = sof ? FRESH : st_q;
    assign take = byte_vld && base.armed && (base.cnt < FULL_CNT);

    af_crc_byte u_crc (
        .crc_in  (base.crc),
        .data    (byte_in),
        .crc_out (crc_nxt)
    );

    af_ucast_cmp #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (CNT_W)
    ) u_cmp (
        .own_addr (own_addr),
        .idx      (base.cnt),
        .data     (byte_in),
        .equal    (byte_eq)
    );

    assign grp_nxt  = (base.cnt == '0) ? byte_in[0] : base.group;
    assign uc_nxt   = base.uc_ok && byte_eq;
    assign ones_nxt = base.ones && (byte_in == 8'hFF);

    af_decide #(
        .HASH_BITS (HASH_BITS)
    ) u_dec (
        .crc         (crc_nxt),
        .uc_equal    (uc_nxt),
        .all_ones    (ones_nxt),
        .group_bit   (grp_nxt),
        .hash_filter (hash_filter),
        .bcast_en    (bcast_en),
        .mcast_en    (mcast_en),
        .promisc     (promisc),
        .cls         (cls_dec),
        .accept      (acc_dec)
    );

    always_comb begin
        st_d = base;
        if (take) begin
            st_d.cnt   = base.cnt + CNT_W'(1);
            st_d.crc   = crc_nxt;
            st_d.uc_ok = uc_nxt;
            st_d.ones  = ones_nxt;
            st_d.group = grp_nxt;
            if (base.cnt == LAST_IDX) begin
                st_d.dvld = 1'b1;
                st_d.acc  = acc_dec;
                st_d.cls  = cls_dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign decision_vld = st_q.dvld;
    assign accept       = st_q.acc;
    assign match_class  = st_q.cls;
endmodule

// File: rtl/af_filter_chk.sv
module af_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sof,
    input logic       byte_vld,
    input logic       promisc,
    input logic       decision_vld,
    input logic       accept,
    input logic [1:0] match_class
);
    // R1
    quiet_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_vld |-> (!accept && match_class == 2'd0));

    // R2
    rise_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!decision_vld && !byte_vld) |=> !decision_vld);

    // R7
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_vld && !sof) |=> decision_vld);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_vld && !sof) |=> ($stable(accept) && $stable(match_class)));

    // R7
    sof_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !decision_vld);

    // R3
    class_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_class != 2'd0) |-> accept);

    // R6
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!decision_vld && promisc && byte_vld && !sof) |=> (!decision_vld || accept));
endmodule

bind af_filter_top af_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .byte_vld     (byte_vld),
    .promisc      (promisc),
    .decision_vld (decision_vld),
    .accept       (accept),
    .match_class  (match_class)
);

// File: tb/sim_af_filter_top.sv
module sim_af_filter_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [47:0] own_addr = 48'h0;
    logic [63:0] hash_filter = 64'h0;
    logic        bcast_en = 1'b0;
    logic        mcast_en = 1'b0;
    logic        promisc = 1'b0;
    logic        decision_vld;
    logic        accept;
    logic [1:0]  match_class;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [47:0] OWN = 48'h5544_3322_1100 | 48'h0000_0000_00AA;

    always #2 clk = ~clk;

    af_filter_top u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_in(byte_in), .own_addr(own_addr), .hash_filter(hash_filter),
        .bcast_en(bcast_en), .mcast_en(mcast_en), .promisc(promisc),
        .decision_vld(decision_vld), .accept(accept), .match_class(match_class)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
        end
        return c[31:26];
    endfunction

    function automatic logic [1:0] model_cls(input logic [47:0] a);
        if (a == 48'hFFFF_FFFF_FFFF) return bcast_en ? 2'd3 : 2'd0;
        if (a[0]) return (mcast_en && hash_filter[hash_of(a)]) ? 2'd2 : 2'd0;
        return (a == own_addr) ? 2'd1 : 2'd0;
    endfunction

    task automatic put_byte(input logic [7:0] b, input logic s);
        @(negedge clk);
        byte_vld = 1'b1; byte_in = b; sof = s;
        @(negedge clk);
        byte_vld = 1'b0; sof = 1'b0;
    endtask

    // sends one six-byte address with optional idle gaps; checks timing and result
    task automatic run_addr(input string req, input logic [47:0] a, input int gap);
        logic [1:0] ec;
        for (int i = 0; i < 6; i++) begin
            put_byte(a[8*i +: 8], i == 0);
            for (int g = 0; g < gap; g++) @(negedge clk);
            if (i == 0) check("R7", "valid cleared after sof", decision_vld, 0);
            if (i == 4) check("R2", "not valid after fifth byte", decision_vld, 0);
        end
        ec = model_cls(a);
        if (gap == 0) check("R2", "valid after sixth byte", decision_vld, 1);
        else          check("R2", "valid after gapped bytes", decision_vld, 1);
        check(req, "class", match_class, ec);
        check(req, "accept", accept, promisc || (ec != 2'd0));
    endtask

    task automatic t_reset;
        check("R1", "reset valid", decision_vld, 0);
        check("R1", "reset accept", accept, 0);
        check("R1", "reset class", match_class, 0);
        for (int i = 0; i < 6; i++) put_byte(OWN[8*i +: 8], 1'b0);
        @(negedge clk);
        check("R8", "bytes before first sof ignored", decision_vld, 0);
    endtask

    task automatic t_unicast;
        run_addr("R3", own_addr, 0);
        run_addr("R3", own_addr, 2);
        for (int k = 0; k < 6; k++) run_addr("R3", own_addr ^ (48'h10 << (8*k)), 0);
    endtask

    task automatic t_broadcast;
        bcast_en = 1'b1;
        run_addr("R4", 48'hFFFF_FFFF_FFFF, 0);
        check("R4", "bcast class 3", match_class, 3);
        bcast_en = 1'b0; mcast_en = 1'b1; hash_filter = '1;
        run_addr("R4", 48'hFFFF_FFFF_FFFF, 0);
        check("R4", "disabled bcast not hashed", match_class, 0);
        hash_filter = '0; mcast_en = 1'b0;
    endtask

    task automatic t_multicast;
        logic [47:0] m;
        logic [5:0]  h;
        m = 48'h0100_5E00_0001 | 48'h1;
        m = {m[47:8], 8'h01};
        h = hash_of(m);
        mcast_en = 1'b1;
        hash_filter = 64'h1 << h;
        run_addr("R5", m, 0);
        check("R5", "hash hit class 2", match_class, 2);
        hash_filter = ~(64'h1 << h);
        run_addr("R5", m, 1);
        check("R5", "hash miss rejected", accept, 0);
        hash_filter = 64'h1 << h; mcast_en = 1'b0;
        run_addr("R5", m, 0);
        check("R5", "mcast disabled rejected", accept, 0);
        m = 48'h1234_5678_9A33;
        mcast_en = 1'b1;
        hash_filter = 64'h1 << hash_of(m);
        run_addr("R5", m, 0);
        hash_filter = '0; mcast_en = 1'b0;
    endtask

    task automatic t_promisc;
        promisc = 1'b1;
        run_addr("R6", 48'h0000_0000_0002, 0);
        check("R6", "promisc class none", match_class, 0);
        check("R6", "promisc accept", accept, 1);
        run_addr("R6", own_addr, 0);
        check("R6", "promisc unicast class", match_class, 1);
        promisc = 1'b0;
    endtask

    task automatic t_hold_restart;
        logic [47:0] other;
        other = 48'h0000_0000_0004;
        run_addr("R7", own_addr, 0);
        for (int i = 0; i < 6; i++) put_byte(other[8*i +: 8], 1'b0);
        repeat (3) @(negedge clk);
        check("R7", "held valid after extra bytes", decision_vld, 1);
        check("R7", "held class after extra bytes", match_class, 1);
        check("R7", "held accept after extra bytes", accept, 1);
        // restart mid-address
        put_byte(other[7:0], 1'b1);
        put_byte(other[15:8], 1'b0);
        put_byte(other[23:16], 1'b0);
        run_addr("R8", own_addr, 0);
        check("R8", "restart gives fresh match", match_class, 1);
        put_byte(own_addr[7:0], 1'b1);
        put_byte(own_addr[15:8], 1'b0);
        run_addr("R8", other, 0);
        check("R8", "restart mismatch rejected", accept, 0);
    endtask

    initial begin
        own_addr = OWN;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_reset;
        t_unicast;
        t_broadcast;
        t_multicast;
        t_promisc;
        t_hold_restart;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule